// File: doc/BRIEF.md
# Nickel Battery Charge State Controller

This block is the supervisory sequencer of a standalone charger for NiMH and NiCd packs. Analog comparators and the termination detectors elsewhere on the chip produce digital flags for input presence, supply level, charger headroom, several cell-voltage thresholds, the temperature window, pause, the chemistry strap and the two termination events. The block filters those flags and moves through shutdown, qualification, precharge, fast charge, top-off, automatic recharge and a latched fault state. From that state it selects the charge-current level for the PWM loop and drives the active-low status lines and the cell-divider enable.

An internal charge timer, sized by the maximum fast-charge period, provides the precharge limit and the early fast-charge check at one twelfth of that period, the top-off length at one third, and the fast-charge limit at the full period. The timer stops while charging is paused or suspended for temperature. A temperature excursion shows a fault but does not latch it. A voltage fault latches until the battery is taken out or input power goes away.

Top module: `chg_ctrl`

## Requirements
- R1: While the filtered input-present flag is low, the state is shutdown and all outputs are inactive: ready_n, fault_n, chrg_n and toc_n are 1, div_en is 0 and cur_lvl is 0. Losing input sends any state to shutdown.
- R2: In qualification, div_en is 1 and cur_lvl is 0. ready_n is 0 only when the supply, headroom and battery-present flags are all high and the overvoltage flag is low. With no battery, every status line stays inactive.
- R3: A cell-overvoltage flag with the battery present and supply good enters the fault state. The outputs there are fault_n=0, ready_n=chrg_n=toc_n=1, div_en=1 and cur_lvl=0.
- R4: Charging starts in precharge when the cell-above-900 mV flag is low and in fast charge otherwise. Precharge drives cur_lvl=1 (one fifth). Fast charge drives cur_lvl=2 (full). Both show ready_n=0 and chrg_n=0. Precharge moves to fast charge once the 900 mV flag rises.
- R5: A precharge that lasts TMAX/12 timer counts without reaching the 900 mV flag enters the fault state.
- R6: A fast charge that started with the cell below the recharge threshold faults at TMAX/12 if the cell-above-1.22 V flag is low. Any fast charge that reaches TMAX counts faults.
- R7: The voltage-drop termination event ends fast charge into automatic recharge. It is ignored until TMAX/12 when fast charge began with the cell below the recharge threshold.
- R8: A slope termination in fast charge goes to top-off only when the NiMH strap is high and TMAX/12 has passed. Top-off drives cur_lvl=3 (one tenth), ready_n, chrg_n and toc_n all 0, and ends after TMAX/3 counts in automatic recharge. Otherwise a slope termination goes straight to automatic recharge.
- R9: Automatic recharge shows ready_n=0 only, with div_en=1 and cur_lvl=0. When the cell-above-recharge flag falls with the battery present, a new fast charge begins with the timer cleared.
- R10: In qualification, a low start-temperature flag shows ready_n=0 and fault_n=0 and charging does not begin. While charging, a low run-temperature flag sets cur_lvl=0, adds fault_n=0 and freezes the state and the timer. The prior state resumes when the flag returns.
- R11: While charging, the pause flag sets cur_lvl=0, freezes the state and the timer, and leaves all status lines unchanged.
- R12: The fault state holds until the battery-present flag falls or input is lost. Battery removal from any powered state returns to qualification, and reinsertion restarts the cycle.
- R13: Every flag is synchronized and acts only after DEB consecutive equal samples. A pulse shorter than DEB cycles has no effect.
- R14: The headroom flag is not required once charging has begun. A low supply flag during charging returns to qualification.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dc_in | input | 1 | DC input present |
| vcc_ok | input | 1 | Supply at or above undervoltage limit |
| hdrm_ok | input | 1 | Supply sufficiently above battery |
| cell_present | input | 1 | Cell voltage above 350 mV |
| cell_ovp | input | 1 | Cell voltage above 1.95 V |
| cell_pre_ok | input | 1 | Cell voltage at or above 900 mV |
| cell_fast_ok | input | 1 | Cell voltage above 1.22 V |
| cell_hi | input | 1 | Cell voltage above the 1.325 V recharge threshold |
| temp_start_ok | input | 1 | Temperature inside the start window |
| temp_run_ok | input | 1 | Temperature inside the running window |
| pause_req | input | 1 | Temperature input below pause threshold |
| chem_nimh | input | 1 | 1 selects NiMH, 0 selects NiCd |
| term_dv | input | 1 | Voltage-drop termination detected |
| term_slope | input | 1 | Temperature-slope termination detected |
| ready_n | output | 1 | Ready status, active low |
| fault_n | output | 1 | Fault status, active low |
| chrg_n | output | 1 | Charging status, active low |
| toc_n | output | 1 | Top-off status, active low |
| div_en | output | 1 | Cell divider enable, active high |
| cur_lvl | output | 2 | Current level: 0 off, 1 fifth, 2 full, 3 tenth |

## Verification
Packs are offered at several starting cell voltages: below 900 mV, between 900 mV and the recharge threshold, and above it. This separates the precharge path, the delayed-termination fast charge and the immediate-termination fast charge. Slope terminations arrive early and late, under both chemistry straps, so the bench can tell top-off apart from direct recharge. Temperature loss, pause, overvoltage, battery removal, supply loss and short glitches are each applied inside a live charge state. Each case shows whether that event freezes, suspends, latches, restarts or is ignored, and the timer limits show whether the freeze really held the time.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_SHDN = 3'd0,
    ST_QUAL = 3'd1,
    ST_PRE  = 3'd2,
    ST_FAST = 3'd3,
    ST_TOP  = 3'd4,
    ST_RCHG = 3'd5,
    ST_FLT  = 3'd6
  } chg_state_t;

  typedef enum logic [1:0] {
    LV_OFF   = 2'd0,
    LV_FIFTH = 2'd1,
    LV_FULL  = 2'd2,
    LV_TENTH = 2'd3
  } chg_lvl_t;

  localparam int F_DC     = 0;
  localparam int F_VCC    = 1;
  localparam int F_HDRM   = 2;
  localparam int F_PRES   = 3;
  localparam int F_OVP    = 4;
  localparam int F_PRE    = 5;
  localparam int F_FAST   = 6;
  localparam int F_HI     = 7;
  localparam int F_TSTART = 8;
  localparam int F_TRUN   = 9;
  localparam int F_PAUSE  = 10;
  localparam int F_NIMH   = 11;
  localparam int F_DV     = 12;
  localparam int F_DT     = 13;
  localparam int NFLAG    = 14;

endpackage

// File: rtl/chg_flag_filter.sv
module chg_flag_filter #(
  parameter int NF  = 14,
  parameter int DEB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] raw,
  output logic [NF-1:0] flt
);

  localparam int CW = (DEB > 1) ? $clog2(DEB + 1) : 1;
  localparam logic [CW-1:0] CLIM = CW'(DEB - 1);

  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_flag
      logic          s1, s2;
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          s1       <= 1'b0;
          s2       <= 1'b0;
          cnt      <= '0;
          flt[g]   <= 1'b0;
        end else begin
          s1 <= raw[g];
          s2 <= s1;
          if (s2 != flt[g]) begin
            if (cnt == CLIM) begin
              flt[g] <= s2;
              cnt    <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            cnt <= '0;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/chg_timer.sv
module chg_timer #(
  parameter int TMAX = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic at_t12,
  output logic at_t3,
  output logic at_tmax
);

  localparam int W = $clog2(TMAX + 1);
  localparam logic [W-1:0] L12  = W'(TMAX / 12);
  localparam logic [W-1:0] L3   = W'(TMAX / 3);
  localparam logic [W-1:0] LMAX = W'(TMAX);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run && (cnt != LMAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_t12  = (cnt >= L12);
  assign at_t3   = (cnt >= L3);
  assign at_tmax = (cnt >= LMAX);

endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flt,
  input  logic             at_t12,
  input  logic             at_t3,
  input  logic             at_tmax,
  output chg_state_t       state_q,
  output logic             tmr_clr,
  output logic             tmr_run
);

  chg_state_t state_nx;
  logic       dv_q, dv_nx;
  logic       charging, hold;

  assign charging = (state_q == ST_PRE) || (state_q == ST_FAST) ||
                    (state_q == ST_TOP);
  assign hold     = charging && (flt[F_PAUSE] || !flt[F_TRUN]);

  always_comb begin
    state_nx = state_q;
    dv_nx    = dv_q;
    if (!flt[F_DC]) begin
      state_nx = ST_SHDN;
    end else begin
      unique case (state_q)
        ST_SHDN: state_nx = ST_QUAL;
        ST_QUAL: begin
          if (flt[F_PRES]) begin
            if (flt[F_OVP]) begin
              state_nx = ST_FLT;
            end else if (flt[F_VCC] && flt[F_HDRM] && !flt[F_PAUSE] &&
                         flt[F_TSTART]) begin
              if (flt[F_PRE]) begin
                state_nx = ST_FAST;
                dv_nx    = flt[F_HI];
              end else begin
                state_nx = ST_PRE;
              end
            end
          end
        end
        ST_PRE, ST_FAST, ST_TOP: begin
          if (!flt[F_PRES] || !flt[F_VCC]) begin
            state_nx = ST_QUAL;
          end else if (flt[F_OVP]) begin
            state_nx = ST_FLT;
          end else if (!hold) begin
            if (state_q == ST_PRE) begin
              if (flt[F_PRE]) begin
                state_nx = ST_FAST;
                dv_nx    = flt[F_HI];
              end else if (at_t12) begin
                state_nx = ST_FLT;
              end
            end else if (state_q == ST_FAST) begin
              if (at_tmax) begin
                state_nx = ST_FLT;
              end else if (at_t12 && !dv_q && !flt[F_FAST]) begin
                state_nx = ST_FLT;
              end else if (flt[F_DT] && flt[F_NIMH] && at_t12) begin
                state_nx = ST_TOP;
              end else if (flt[F_DT]) begin
                state_nx = ST_RCHG;
              end else if (flt[F_DV] && dv_q) begin
                state_nx = ST_RCHG;
              end else if (at_t12 && !dv_q) begin
                dv_nx = 1'b1;
              end
            end else begin
              if (at_t3) state_nx = ST_RCHG;
            end
          end
        end
        ST_RCHG: begin
          if (!flt[F_PRES]) begin
            state_nx = ST_QUAL;
          end else if (flt[F_OVP]) begin
            state_nx = ST_FLT;
          end else if (!flt[F_HI]) begin
            state_nx = ST_FAST;
            dv_nx    = 1'b1;
          end
        end
        ST_FLT: begin
          if (!flt[F_PRES]) state_nx = ST_QUAL;
        end
        default: state_nx = ST_SHDN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SHDN;
      dv_q    <= 1'b0;
    end else begin
      state_q <= state_nx;
      dv_q    <= dv_nx;
    end
  end

  assign tmr_clr = (state_nx != state_q);
  assign tmr_run = charging && !hold;

endmodule

// File: rtl/chg_out.sv
module chg_out
  import chg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  chg_state_t       state_q,
  input  logic [NFLAG-1:0] flt,
  output logic             ready_n,
  output logic             fault_n,
  output logic             chrg_n,
  output logic             toc_n,
  output logic             div_en,
  output logic [1:0]       cur_lvl
);

  logic     qual_ok, hold;
  chg_lvl_t lvl;

  assign qual_ok = flt[F_VCC] && flt[F_HDRM] && flt[F_PRES] && !flt[F_OVP];
  assign hold    = flt[F_PAUSE] || !flt[F_TRUN];

  always_comb begin
    unique case (state_q)
      ST_PRE:  lvl = LV_FIFTH;
      ST_FAST: lvl = LV_FULL;
      ST_TOP:  lvl = LV_TENTH;
      default: lvl = LV_OFF;
    endcase
    if (hold) lvl = LV_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_n <= 1'b1;
      fault_n <= 1'b1;
      chrg_n  <= 1'b1;
      toc_n   <= 1'b1;
      div_en  <= 1'b0;
      cur_lvl <= LV_OFF;
    end else begin
      ready_n <= 1'b1;
      fault_n <= 1'b1;
      chrg_n  <= 1'b1;
      toc_n   <= 1'b1;
      div_en  <= 1'b1;
      cur_lvl <= LV_OFF;
      unique case (state_q)
        ST_SHDN: div_en <= 1'b0;
        ST_QUAL: begin
          ready_n <= !qual_ok;
          fault_n <= !(qual_ok && !flt[F_PAUSE] && !flt[F_TSTART]);
        end
        ST_PRE, ST_FAST, ST_TOP: begin
          ready_n <= 1'b0;
          chrg_n  <= 1'b0;
          toc_n   <= (state_q != ST_TOP);
          fault_n <= !(!flt[F_TRUN] && !flt[F_PAUSE]);
          cur_lvl <= lvl;
        end
        ST_RCHG: ready_n <= 1'b0;
        ST_FLT:  fault_n <= 1'b0;
        default: div_en <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/chg_ctrl.sv
module chg_ctrl
  import chg_pkg::*;
#(
  parameter int DEB  = 4,
  parameter int TMAX = 1200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dc_in,
  input  logic       vcc_ok,
  input  logic       hdrm_ok,
  input  logic       cell_present,
  input  logic       cell_ovp,
  input  logic       cell_pre_ok,
  input  logic       cell_fast_ok,
  input  logic       cell_hi,
  input  logic       temp_start_ok,
  input  logic       temp_run_ok,
  input  logic       pause_req,
  input  logic       chem_nimh,
  input  logic       term_dv,
  input  logic       term_slope,
  output logic       ready_n,
  output logic       fault_n,
  output logic       chrg_n,
  output logic       toc_n,
  output logic       div_en,
  output logic [1:0] cur_lvl
);

  logic [NFLAG-1:0] raw, flt;
  chg_state_t       state_q;
  logic             tmr_clr, tmr_run, at_t12, at_t3, at_tmax;

  always_comb begin
    raw           = '0;
    raw[F_DC]     = dc_in;
    raw[F_VCC]    = vcc_ok;
    raw[F_HDRM]   = hdrm_ok;
    raw[F_PRES]   = cell_present;
    raw[F_OVP]    = cell_ovp;
    raw[F_PRE]    = cell_pre_ok;
    raw[F_FAST]   = cell_fast_ok;
    raw[F_HI]     = cell_hi;
    raw[F_TSTART] = temp_start_ok;
    raw[F_TRUN]   = temp_run_ok;
    raw[F_PAUSE]  = pause_req;
    raw[F_NIMH]   = chem_nimh;
    raw[F_DV]     = term_dv;
    raw[F_DT]     = term_slope;
  end

  chg_flag_filter #(.NF(NFLAG), .DEB(DEB)) u_filt (
    .clk(clk), .rst(rst), .raw(raw), .flt(flt)
  );

  chg_timer #(.TMAX(TMAX)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run),
    .at_t12(at_t12), .at_t3(at_t3), .at_tmax(at_tmax)
  );

  chg_fsm u_fsm (
    .clk(clk), .rst(rst), .flt(flt), .at_t12(at_t12), .at_t3(at_t3),
    .at_tmax(at_tmax), .state_q(state_q), .tmr_clr(tmr_clr),
    .tmr_run(tmr_run)
  );

  chg_out u_out (
    .clk(clk), .rst(rst), .state_q(state_q), .flt(flt),
    .ready_n(ready_n), .fault_n(fault_n), .chrg_n(chrg_n), .toc_n(toc_n),
    .div_en(div_en), .cur_lvl(cur_lvl)
  );

endmodule

// File: rtl/chg_ctrl_chk.sv
module chg_ctrl_chk
  import chg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input chg_state_t       state_q,
  input logic [NFLAG-1:0] flt,
  input logic             ready_n,
  input logic             fault_n,
  input logic             chrg_n,
  input logic             toc_n,
  input logic             div_en,
  input logic [1:0]       cur_lvl
);

  logic live;
  assign live = (state_q == ST_PRE) || (state_q == ST_FAST) ||
                (state_q == ST_TOP);

  assert_inputloss_R1: assert property (@(posedge clk) disable iff (rst)
    !flt[F_DC] |=> state_q == ST_SHDN);

  assert_ready_div_R2: assert property (@(posedge clk) disable iff (rst)
    !ready_n |-> div_en);

  assert_ovp_R3: assert property (@(posedge clk) disable iff (rst)
    (flt[F_DC] && flt[F_PRES] && flt[F_VCC] && flt[F_OVP] &&
     state_q != ST_SHDN) |=> state_q == ST_FLT);

  assert_lvl_status_R4: assert property (@(posedge clk) disable iff (rst)
    (cur_lvl != 2'd0) |-> (!chrg_n && !ready_n && fault_n));

  assert_toc_chrg_R8: assert property (@(posedge clk) disable iff (rst)
    !toc_n |-> !chrg_n);

  assert_recharge_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RCHG && flt[F_DC] && flt[F_PRES] && !flt[F_OVP] &&
     !flt[F_HI]) |=> state_q == ST_FAST);

  assert_pause_R11: assert property (@(posedge clk) disable iff (rst)
    (live && flt[F_DC] && flt[F_PRES] && flt[F_VCC] && !flt[F_OVP] &&
     flt[F_PAUSE]) |=> $stable(state_q));

  assert_fault_latch_R12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FLT && flt[F_DC] && flt[F_PRES]) |=> state_q == ST_FLT);

endmodule

bind chg_ctrl chg_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .flt(flt),
  .ready_n(ready_n), .fault_n(fault_n), .chrg_n(chrg_n), .toc_n(toc_n),
  .div_en(div_en), .cur_lvl(cur_lvl)
);

// File: tb/test_chg_ctrl.sv
module test_chg_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 3;
  localparam int TMAX = 600;
  localparam int SET  = 12;

  localparam logic [6:0] O_OFF   = 7'b1111_0_00;
  localparam logic [6:0] O_NOBAT = 7'b1111_1_00;
  localparam logic [6:0] O_READY = 7'b0111_1_00;
  localparam logic [6:0] O_QTEMP = 7'b0011_1_00;
  localparam logic [6:0] O_PRE   = 7'b0101_1_01;
  localparam logic [6:0] O_FAST  = 7'b0101_1_10;
  localparam logic [6:0] O_HOLD  = 7'b0101_1_00;
  localparam logic [6:0] O_TEMPS = 7'b0001_1_00;
  localparam logic [6:0] O_TOP   = 7'b0100_1_11;
  localparam logic [6:0] O_FAULT = 7'b1011_1_00;

  logic clk = 1'b0;
  logic rst;
  logic dc_in, vcc_ok, hdrm_ok, cell_present, cell_ovp, cell_pre_ok;
  logic cell_fast_ok, cell_hi, temp_start_ok, temp_run_ok, pause_req;
  logic chem_nimh, term_dv, term_slope;
  logic ready_n, fault_n, chrg_n, toc_n, div_en;
  logic [1:0] cur_lvl;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chg_ctrl #(.DEB(DEB), .TMAX(TMAX)) i_chg_ctrl (
    .clk(clk), .rst(rst), .dc_in(dc_in), .vcc_ok(vcc_ok), .hdrm_ok(hdrm_ok),
    .cell_present(cell_present), .cell_ovp(cell_ovp),
    .cell_pre_ok(cell_pre_ok), .cell_fast_ok(cell_fast_ok),
    .cell_hi(cell_hi), .temp_start_ok(temp_start_ok),
    .temp_run_ok(temp_run_ok), .pause_req(pause_req),
    .chem_nimh(chem_nimh), .term_dv(term_dv), .term_slope(term_slope),
    .ready_n(ready_n), .fault_n(fault_n), .chrg_n(chrg_n), .toc_n(toc_n),
    .div_en(div_en), .cur_lvl(cur_lvl)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [6:0] exp);
    logic [6:0] got;
    got = {ready_n, fault_n, chrg_n, toc_n, div_en, cur_lvl};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic clear_all();
    dc_in = 0; vcc_ok = 0; hdrm_ok = 0; cell_present = 0; cell_ovp = 0;
    cell_pre_ok = 0; cell_fast_ok = 0; cell_hi = 0; temp_start_ok = 0;
    temp_run_ok = 0; pause_req = 0; chem_nimh = 0; term_dv = 0;
    term_slope = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_all();
    rst = 1;
    cyc(3);
    rst = 0;
    cyc(2);
  endtask

  task automatic power_up(input logic pre, input logic fast, input logic hi,
                          input logic nimh);
    dc_in = 1; vcc_ok = 1; hdrm_ok = 1; cell_present = 1;
    temp_start_ok = 1; temp_run_ok = 1;
    cell_pre_ok = pre; cell_fast_ok = fast; cell_hi = hi; chem_nimh = nimh;
  endtask

  task automatic t_reset_and_qual();
    do_reset();
    chk("R1 reset state", O_OFF);
    cyc(SET);
    chk("R1 idle without input", O_OFF);
    dc_in = 1; vcc_ok = 1; hdrm_ok = 1;
    cyc(SET);
    chk("R2 qualification without battery", O_NOBAT);
    temp_start_ok = 1; temp_run_ok = 1; cell_present = 1;
    cyc(SET);
    chk("R4 low cell enters precharge", O_PRE);
    cell_pre_ok = 1; cell_fast_ok = 1;
    cyc(SET);
    chk("R4 precharge advances to fast", O_FAST);
    dc_in = 0;
    cyc(SET);
    chk("R1 input loss from fast", O_OFF);
  endtask

  task automatic t_pre_timeout_removal();
    do_reset();
    power_up(0, 0, 0, 0);
    cyc(SET);
    chk("R5 in precharge", O_PRE);
    cyc(70);
    chk("R5 precharge limit faults", O_FAULT);
    cyc(20);
    chk("R12 fault latched", O_FAULT);
    cell_present = 0;
    cyc(SET);
    chk("R12 removal returns to qualification", O_NOBAT);
    cell_present = 1;
    cyc(SET);
    chk("R12 reinsertion restarts", O_PRE);
  endtask

  task automatic t_fast_early_fault();
    do_reset();
    power_up(1, 0, 0, 0);
    cyc(SET);
    chk("R6 fast with weak cell", O_FAST);
    cyc(70);
    chk("R6 early check faults", O_FAULT);
  endtask

  task automatic t_fast_tmax();
    do_reset();
    power_up(1, 1, 0, 0);
    cyc(SET);
    cyc(400);
    chk("R6 fast before limit", O_FAST);
    cyc(250);
    chk("R6 fast limit faults", O_FAULT);
  endtask

  task automatic t_dv_window();
    do_reset();
    power_up(1, 1, 0, 0);
    term_dv = 1;
    cyc(SET);
    cyc(20);
    chk("R7 voltage drop ignored in window", O_FAST);
    cell_hi = 1;
    cyc(60);
    chk("R7 voltage drop terminates after window", O_READY);
    term_dv = 0;
    cyc(SET);
    chk("R9 recharge idle while cell high", O_READY);
    cell_hi = 0;
    cyc(SET);
    chk("R9 cell drop restarts fast", O_FAST);
  endtask

  task automatic t_nimh_topoff();
    do_reset();
    power_up(1, 1, 1, 1);
    cyc(SET);
    cyc(60);
    term_slope = 1;
    cyc(SET);
    chk("R8 NiMH late slope enters top-off", O_TOP);
    term_slope = 0;
    cyc(150);
    chk("R8 top-off still running", O_TOP);
    cyc(80);
    chk("R8 top-off ends in recharge", O_READY);
  endtask

  task automatic t_slope_no_topoff();
    do_reset();
    power_up(1, 1, 1, 0);
    cyc(SET);
    cyc(60);
    term_slope = 1;
    cyc(SET);
    chk("R8 NiCd slope skips top-off", O_READY);
    do_reset();
    power_up(1, 1, 1, 1);
    term_slope = 1;
    cyc(20);
    chk("R8 NiMH early slope skips top-off", O_READY);
  endtask

  task automatic t_temperature();
    do_reset();
    power_up(0, 0, 0, 0);
    temp_start_ok = 0;
    cyc(SET);
    chk("R10 start temperature blocks charging", O_QTEMP);
    cyc(40);
    chk("R10 still waiting on temperature", O_QTEMP);
    temp_start_ok = 1;
    cyc(SET);
    chk("R10 start after temperature ok", O_PRE);
    temp_run_ok = 0;
    cyc(100);
    chk("R10 running temperature suspends", O_TEMPS);
    temp_run_ok = 1;
    cyc(SET);
    chk("R10 resumes prior state with timer held", O_PRE);
    cyc(60);
    chk("R5 timer resumes to limit", O_FAULT);
  endtask

  task automatic t_pause();
    do_reset();
    power_up(1, 1, 1, 0);
    cyc(SET);
    pause_req = 1;
    cyc(SET);
    chk("R11 pause removes current only", O_HOLD);
    cyc(700);
    chk("R11 pause holds past limit", O_HOLD);
    pause_req = 0;
    cyc(SET);
    chk("R11 timer frozen during pause", O_FAST);
  endtask

  task automatic t_glitch_supply();
    do_reset();
    power_up(1, 1, 1, 0);
    cyc(SET);
    dc_in = 0;
    cyc(2);
    dc_in = 1;
    cyc(SET);
    chk("R13 input glitch ignored", O_FAST);
    hdrm_ok = 0;
    cyc(SET);
    chk("R14 headroom not needed while charging", O_FAST);
    vcc_ok = 0;
    cyc(SET);
    chk("R14 supply low returns to qualification", O_NOBAT);
    cell_present = 0; vcc_ok = 1; hdrm_ok = 1;
    cyc(SET);
    cell_present = 1;
    cyc(2);
    cell_present = 0;
    cyc(SET);
    chk("R13 presence glitch ignored", O_NOBAT);
  endtask

  task automatic t_ovp();
    do_reset();
    power_up(1, 1, 1, 0);
    cyc(SET);
    cell_ovp = 1;
    cyc(SET);
    chk("R3 overvoltage faults", O_FAULT);
    cell_ovp = 0;
    cyc(SET);
    chk("R12 fault stays after overvoltage clears", O_FAULT);
    dc_in = 0;
    cyc(SET);
    chk("R1 input loss clears fault", O_OFF);
    dc_in = 1; cell_pre_ok = 0;
    cyc(SET);
    chk("R12 input cycle restarts", O_PRE);
    do_reset();
    power_up(1, 1, 1, 0);
    cell_ovp = 1;
    cyc(SET);
    chk("R3 overvoltage in qualification", O_FAULT);
  endtask

  initial begin
    rst = 1;
    clear_all();
    t_reset_and_qual();
    t_pre_timeout_removal();
    t_fast_early_fault();
    t_fast_tmax();
    t_dv_window();
    t_nimh_topoff();
    t_slope_no_topoff();
    t_temperature();
    t_pause();
    t_glitch_supply();
    t_ovp();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule